// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable performance-monitoring counter. Each cycle it sees several groups of eight event lines and two tracker counts: the number of tracker entries that are valid and the number allocated in that cycle. A configuration word picks one group and a unit mask for it. It also picks an event class, a threshold, an invert flag, an edge-detect flag and an enable. From these the block works out a raw per-cycle count, then shapes it with the qualifiers and adds the result to a 48-bit counter.

For the two line-based classes the unit mask is split into state bits and filter bits. The raw count is the number of selected state lines that are active, and it is taken only when at least one selected filter line is also active. A unit mask that leaves either group empty is rejected. In that case nothing is counted and a sticky error flag is raised. The occupancy class adds the valid-entry count every cycle. The request class adds the allocation count.

Software reaches the configuration, the counter and the status through a small register port. The port writes in one cycle and reads combinationally. The event and tracker inputs are sampled on every clock and have no handshake. A monitor cannot stall the logic it watches, so there is no back-pressure toward the event sources.

Top module: `evt_qual_counter`

## Requirements
- R1: With threshold 0 and edge off, each enabled cycle adds the raw count. For line classes the raw count is popcount(lines & umask & state_bits) when (lines & umask & filter_bits) is nonzero, and 0 otherwise.
- R2: With a nonzero threshold and invert clear, an enabled cycle adds 1 when raw >= threshold, else 0.
- R3: With a nonzero threshold and invert set, an enabled cycle adds 1 when raw < threshold. Invert has no effect while the threshold is 0.
- R4: With edge on, the counter adds 1 only in a cycle where the qualified condition is true after being false in the previous cycle. For threshold 0 that condition is raw != 0. The history bit is cleared on reset and by every configuration write.
- R5: Class 0 (lookup) uses umask[3:0] as state bits and umask[7:4] as filter bits. Class 1 (snoop) uses umask[4:0] as state bits and umask[7:5] as filter bits. If either group is empty while the counter is enabled, the counter does not change and the error flag is set.
- R6: Class 2 (occupancy) takes the raw count from trk_occ. Class 3 (request) takes it from trk_alloc. The same qualifiers then apply, and the unit mask is not checked.
- R7: A counter write loads reg_wdata even when an increment is due in that cycle. In a cycle with a configuration write, the counter does not change.
- R8: The counter is 48 bits wide and wraps to 0 with no other effect.
- R9: While enable is 0, the counter does not change.
- R10: The error flag is sticky. It is cleared only by writing 1 to status bit 0, and that clear wins over a set in the same cycle.
- R11: Register addresses: 0 is configuration, 1 is counter, 2 is status (bit 0 = error). Configuration fields: umask [7:0], group [9:8], class [11:10], threshold [19:12], edge [20], invert [21], enable [22]. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_lines | input | NUM_GRP*8 | Event lines, eight per group, group g at bits [8g+7:8g] |
| trk_occ | input | TRK_W | Valid tracker entries this cycle |
| trk_alloc | input | TRK_W | Tracker entries allocated this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| cfg_error | output | 1 | Sticky unit-mask error flag |

## Verification
The assertions check these rules on every cycle: write priority, and the counter holding still during configuration writes, while disabled, and under a rejected unit mask. They also check that a nonzero threshold never adds more than one, that an edge increment is never followed at once by another, and that the error flag stays set until it is cleared. Only the bench's scenarios can show the exact amounts added. These include the filter gating of the popcount, the two mask splits, the tracker-fed classes, the inverted comparison, counting that resumes after a history clear, and wrap-around. The bench compares each of these against its own model over random and directed traffic.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int UMASK_W    = 8;
  localparam int THR_W      = 8;
  localparam int GRP_W      = 2;
  localparam int LKP_STATES = 4;
  localparam int SNP_STATES = 5;

  typedef enum logic [1:0] {
    CLS_LOOKUP = 2'd0,
    CLS_SNOOP  = 2'd1,
    CLS_OCCUP  = 2'd2,
    CLS_REQ    = 2'd3
  } evq_class_e;

  typedef struct packed {
    logic             enable;
    logic             invert;
    logic             edge_mode;
    logic [THR_W-1:0] thresh;
    evq_class_e       cls;
    logic [GRP_W-1:0] grp;
    logic [UMASK_W-1:0] umask;
  } evq_cfg_t;

  localparam int CFG_W = $bits(evq_cfg_t);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/evq_mask_check.sv
module evq_mask_check
  import evq_pkg::*;
(
  input  evq_class_e         cls,
  input  logic [UMASK_W-1:0] umask,
  output logic [UMASK_W-1:0] state_mask,
  output logic               mask_ok
);
  localparam logic [UMASK_W-1:0] LKP_MASK = UMASK_W'((1 << LKP_STATES) - 1);
  localparam logic [UMASK_W-1:0] SNP_MASK = UMASK_W'((1 << SNP_STATES) - 1);

  logic line_class;

  always_comb begin
    line_class = 1'b1;
    unique case (cls)
      CLS_LOOKUP: state_mask = LKP_MASK;
      CLS_SNOOP:  state_mask = SNP_MASK;
      default: begin
        state_mask = '0;
        line_class = 1'b0;
      end
    endcase
    // both groups must carry at least one selected bit
    mask_ok = line_class ? ((|(umask & state_mask)) && (|(umask & ~state_mask))) : 1'b1;
  end
endmodule

// File: rtl/evq_event_tally.sv
module evq_event_tally #(
  parameter int LINE_W = 8,
  parameter int OUT_W  = $clog2(LINE_W + 1)
) (
  input  logic [LINE_W-1:0] lines,
  input  logic [LINE_W-1:0] umask,
  input  logic [LINE_W-1:0] state_mask,
  output logic [OUT_W-1:0]  tally
);
  logic [LINE_W-1:0] hit_state;
  logic              hit_filter;
  logic [OUT_W-1:0]  pop;

  always_comb begin
    hit_state  = lines & umask & state_mask;
    hit_filter = |(lines & umask & ~state_mask);
    pop = '0;
    for (int i = 0; i < LINE_W; i++) begin
      pop = pop + OUT_W'(hit_state[i]);
    end
    tally = hit_filter ? pop : '0;
  end
endmodule

// File: rtl/evq_qualifier.sv
module evq_qualifier #(
  parameter int RAW_W = 6,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW_W-1:0] raw,
  input  logic [THR_W-1:0] thresh,
  input  logic             invert,
  input  logic             edge_mode,
  input  logic             active,
  input  logic             hist_clr,
  output logic [RAW_W-1:0] inc
);
  localparam int MW = (RAW_W > THR_W) ? RAW_W : THR_W;

  logic [MW-1:0] raw_x;
  logic [MW-1:0] thr_x;
  logic          thr_zero;
  logic          at_or_above;
  logic          cond;
  logic          hist_q;

  always_comb begin
    raw_x       = MW'(raw);
    thr_x       = MW'(thresh);
    thr_zero    = (thresh == '0);
    at_or_above = (raw_x >= thr_x);
    if (thr_zero) cond = active && (raw != '0);
    else          cond = active && (invert ? !at_or_above : at_or_above);

    if (!active)        inc = '0;
    else if (edge_mode) inc = (cond && !hist_q) ? RAW_W'(1) : '0;
    else if (thr_zero)  inc = raw;
    else                inc = cond ? RAW_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= 1'b0;
    else if (hist_clr) hist_q <= 1'b0;
    else               hist_q <= cond;
  end
endmodule

// File: rtl/evt_qual_counter.sv
module evt_qual_counter
  import evq_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int TRK_W   = 6,
  parameter int CNT_W   = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*UMASK_W-1:0] evt_lines,
  input  logic [TRK_W-1:0]           trk_occ,
  input  logic [TRK_W-1:0]           trk_alloc,
  input  logic                       reg_we,
  input  logic [1:0]                 reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  output logic [CNT_W-1:0]           reg_rdata,
  output logic                       cfg_error
);
  localparam int TALLY_W = $clog2(UMASK_W + 1);
  localparam int RAW_W   = (TRK_W > TALLY_W) ? TRK_W : TALLY_W;

  evq_cfg_t           cfg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               err_q;

  logic               wr_cfg, wr_cnt, wr_stat;
  logic [UMASK_W-1:0] grp_lines [NUM_GRP];
  logic [UMASK_W-1:0] sel_lines;
  logic [UMASK_W-1:0] state_mask;
  logic               mask_ok;
  logic [TALLY_W-1:0] tally;
  logic [RAW_W-1:0]   raw;
  logic [RAW_W-1:0]   inc_amt;
  logic               active;

  assign wr_cfg  = reg_we && (reg_addr == ADDR_CFG);
  assign wr_cnt  = reg_we && (reg_addr == ADDR_CNT);
  assign wr_stat = reg_we && (reg_addr == ADDR_STAT);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_lines[g] = evt_lines[g*UMASK_W +: UMASK_W];
  end

  always_comb begin
    sel_lines = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (GRP_W'(g) == cfg_q.grp) sel_lines = grp_lines[g];
    end
  end

  evq_mask_check u_mask (
    .cls       (cfg_q.cls),
    .umask     (cfg_q.umask),
    .state_mask(state_mask),
    .mask_ok   (mask_ok)
  );

  evq_event_tally #(.LINE_W(UMASK_W), .OUT_W(TALLY_W)) u_tally (
    .lines     (sel_lines),
    .umask     (cfg_q.umask),
    .state_mask(state_mask),
    .tally     (tally)
  );

  always_comb begin
    unique case (cfg_q.cls)
      CLS_OCCUP: raw = RAW_W'(trk_occ);
      CLS_REQ:   raw = RAW_W'(trk_alloc);
      default:   raw = RAW_W'(tally);
    endcase
  end

  assign active = cfg_q.enable && mask_ok;

  evq_qualifier #(.RAW_W(RAW_W), .THR_W(THR_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw),
    .thresh   (cfg_q.thresh),
    .invert   (cfg_q.invert),
    .edge_mode(cfg_q.edge_mode),
    .active   (active),
    .hist_clr (wr_cfg),
    .inc      (inc_amt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= evq_cfg_t'(reg_wdata[CFG_W-1:0]);

      if (wr_cnt)       cnt_q <= reg_wdata;
      else if (!wr_cfg) cnt_q <= cnt_q + CNT_W'(inc_amt);

      if (wr_stat && reg_wdata[0])         err_q <= 1'b0;
      else if (cfg_q.enable && !mask_ok)   err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CFG:  reg_rdata = CNT_W'(cfg_q);
      ADDR_CNT:  reg_rdata = cnt_q;
      ADDR_STAT: reg_rdata = CNT_W'(err_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign cfg_error = err_q;
endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
  parameter int CNT_W = 48,
  parameter int RAW_W = 6,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             err_q,
  input logic             cfg_en,
  input logic             cfg_edge,
  input logic [THR_W-1:0] cfg_thr,
  input logic             mask_ok,
  input logic [RAW_W-1:0] inc
);
  // R7: counter write wins over any increment
  p_cnt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> (cnt_q == $past(reg_wdata)));

  // R7: no counting in a configuration-write cycle
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> (cnt_q == $past(cnt_q)));

  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !reg_we) |=> $stable(cnt_q));

  p_bad_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !mask_ok && !reg_we) |=> ($stable(cnt_q) && err_q));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_thr != '0 && !reg_we) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_edge && inc != '0 && !reg_we) |=> (inc == '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(reg_we && reg_addr == 2'd2 && reg_wdata[0])) |=> err_q);
endmodule

bind evt_qual_counter evq_checker #(
  .CNT_W(CNT_W), .RAW_W(RAW_W), .THR_W(evq_pkg::THR_W)
) u_evq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .cnt_q    (cnt_q),
  .err_q    (err_q),
  .cfg_en   (cfg_q.enable),
  .cfg_edge (cfg_q.edge_mode),
  .cfg_thr  (cfg_q.thresh),
  .mask_ok  (mask_ok),
  .inc      (inc_amt)
);

// File: tb/evt_qual_counter_tb.sv
`timescale 1ns/1ps
module evt_qual_counter_tb;
  localparam int NG = 4;
  localparam int TW = 6;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*8-1:0] evt_lines = '0;
  logic [TW-1:0] trk_occ = '0, trk_alloc = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd1;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          cfg_error;

  always #2.5 clk = ~clk;

  evt_qual_counter #(.NUM_GRP(NG), .TRK_W(TW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_lines(evt_lines), .trk_occ(trk_occ),
    .trk_alloc(trk_alloc), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_error(cfg_error)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  logic [22:0]   m_cfg = '0;
  logic [CW-1:0] m_cnt = '0;
  bit            m_hist = 0;
  bit            m_err = 0;

  function automatic logic [22:0] mkcfg(bit en, bit inv, bit edg, int thr,
                                        int cls, int grp, logic [7:0] um);
    return {en, inv, edg, 8'(thr), 2'(cls), 2'(grp), um};
  endfunction

  function automatic int pop8(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic bit mask_good(logic [22:0] c);
    logic [7:0] sm = (c[11:10] == 2'd0) ? 8'h0F : 8'h1F;
    if (c[11:10] >= 2'd2) return 1;
    return ((c[7:0] & sm) != 0) && ((c[7:0] & ~sm) != 0);
  endfunction

  function automatic int raw_of(logic [22:0] c, logic [NG*8-1:0] ln,
                                int occ, int alc);
    logic [7:0] g = ln[c[9:8]*8 +: 8];
    logic [7:0] sm = (c[11:10] == 2'd0) ? 8'h0F : 8'h1F;
    if (c[11:10] == 2'd2) return occ;
    if (c[11:10] == 2'd3) return alc;
    if ((g & c[7:0] & ~sm) == 0) return 0;
    return pop8(g & c[7:0] & sm);
  endfunction

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit we, logic [1:0] addr, logic [CW-1:0] wd,
                      logic [NG*8-1:0] ln, int occ, int alc, string tag);
    bit en, act, cond, inv, edg;
    int thr, raw, inc;
    @(negedge clk);
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    evt_lines = ln; trk_occ = TW'(occ); trk_alloc = TW'(alc);
    en  = m_cfg[22]; inv = m_cfg[21]; edg = m_cfg[20]; thr = m_cfg[19:12];
    act = en && mask_good(m_cfg);
    raw = raw_of(m_cfg, ln, occ, alc);
    if (thr == 0) cond = act && (raw != 0);
    else          cond = act && (inv ? (raw < thr) : (raw >= thr));
    if (!act)          inc = 0;
    else if (edg)      inc = (cond && !m_hist) ? 1 : 0;
    else if (thr == 0) inc = raw;
    else               inc = cond ? 1 : 0;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    if (we && addr == 2'd1)      m_cnt = wd;
    else if (!(we && addr == 0)) m_cnt = m_cnt + CW'(inc);
    if (we && addr == 2'd2 && wd[0]) m_err = 0;
    else if (en && !mask_good(m_cfg)) m_err = 1;
    m_hist = (we && addr == 0) ? 0 : cond;
    if (we && addr == 0) m_cfg = wd[22:0];
    reg_addr = 2'd1; #0.5;
    chk({tag, " count"}, reg_rdata, m_cnt);
    reg_addr = 2'd2; #0.5;
    chk({tag, " status"}, reg_rdata, CW'(m_err));
  endtask

  task automatic idle(string tag, int n, logic [NG*8-1:0] ln);
    for (int i = 0; i < n; i++) step(0, 2'd1, '0, ln, 3, 1, tag);
  endtask

  task automatic rand_phase(logic [22:0] c, int n, bit dense, string tag);
    step(1, 2'd0, CW'(c), '0, 0, 0, tag);
    for (int i = 0; i < n; i++) begin
      logic [NG*8-1:0] ln = dense ? $urandom : ($urandom & $urandom);
      step(0, 2'd1, '0, ln, $urandom_range(0, 63), $urandom_range(0, 7), tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R11 reset values on all three addresses
    reg_addr = 2'd0; #0.5; chk("R11 reset cfg", reg_rdata, '0);
    reg_addr = 2'd1; #0.5; chk("R11 reset count", reg_rdata, '0);
    reg_addr = 2'd2; #0.5; chk("R11 reset status", reg_rdata, '0);

    // R11 configuration readback
    step(1, 2'd0, CW'(mkcfg(1, 0, 0, 0, 0, 1, 8'h13)), '0, 0, 0, "R11");
    reg_addr = 2'd0; #0.5;
    chk("R11 cfg readback", reg_rdata, CW'(mkcfg(1, 0, 0, 0, 0, 1, 8'h13)));

    // R1 directed: group 1, state bits 0,1 filter bit 4
    step(0, 2'd1, '0, 32'h0000_1300, 0, 0, "R1 two states + filter");
    step(0, 2'd1, '0, 32'h0000_0300, 0, 0, "R1 no filter gives 0");
    step(0, 2'd1, '0, 32'h0000_0013, 0, 0, "R1 other group ignored");
    rand_phase(mkcfg(1, 0, 0, 0, 0, 2, 8'hF5), 300, 1, "R1");
    rand_phase(mkcfg(1, 0, 0, 0, 1, 3, 8'hBF), 300, 1, "R5 snoop split");
    rand_phase(mkcfg(1, 0, 0, 2, 0, 0, 8'hFF), 300, 1, "R2");
    rand_phase(mkcfg(1, 1, 0, 2, 0, 1, 8'hFF), 300, 1, "R3");
    rand_phase(mkcfg(1, 1, 0, 0, 0, 1, 8'hFF), 200, 1, "R3 invert ignored thr0");
    rand_phase(mkcfg(1, 0, 1, 0, 0, 0, 8'h11), 300, 0, "R4");
    rand_phase(mkcfg(1, 0, 1, 20, 2, 0, 8'h00), 300, 1, "R4 occupancy edge");
    rand_phase(mkcfg(1, 0, 0, 0, 2, 0, 8'h00), 300, 1, "R6 occupancy");
    rand_phase(mkcfg(1, 0, 0, 0, 3, 0, 8'h00), 300, 1, "R6 request");
    rand_phase(mkcfg(0, 0, 0, 0, 2, 0, 8'h00), 100, 1, "R9");

    // R4 directed: held condition counts once, config write clears history
    step(1, 2'd0, CW'(mkcfg(1, 0, 1, 1, 0, 0, 8'h11)), 32'h11, 0, 0, "R4 setup");
    idle("R4 held high", 5, 32'h11);
    step(1, 2'd0, CW'(mkcfg(1, 0, 1, 1, 0, 0, 8'h11)), 32'h11, 0, 0, "R4 rewrite");
    idle("R4 after history clear", 2, 32'h11);

    // R7 counter write priority and config-write hold
    step(1, 2'd0, CW'(mkcfg(1, 0, 0, 0, 2, 0, 8'h00)), '0, 9, 0, "R7 cfg write hold");
    step(1, 2'd1, 48'h0000_1234_5678, '0, 9, 0, "R7 write wins");

    // R8 wrap
    step(1, 2'd1, {CW{1'b1}} - 48'd1, '0, 9, 0, "R8 preload");
    step(0, 2'd1, '0, '0, 5, 0, "R8 wrap");

    // R5 invalid masks and R10 sticky/clear
    rand_phase(mkcfg(1, 0, 0, 0, 0, 0, 8'h0F), 40, 1, "R5 no filter bits");
    rand_phase(mkcfg(1, 0, 0, 0, 1, 0, 8'hE0), 40, 1, "R5 no state bits");
    step(1, 2'd0, CW'(mkcfg(0, 0, 0, 0, 1, 0, 8'hE0)), '0, 0, 0, "R10 sticky");
    idle("R10 stays set", 3, '0);
    step(1, 2'd2, 48'h0, '0, 0, 0, "R10 write 0 no clear");
    step(1, 2'd2, 48'h1, '0, 0, 0, "R10 clear");
    chk("R10 pin", CW'(cfg_error), '0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule